// File: doc/BRIEF.md
# Serial Readout Controller for a 12-bit Sampling Converter

This block holds the digital control and output logic of a 12-bit sampling converter whose result is read out one bit at a time. An external controller selects an analog input channel with a write strobe and starts a conversion. The start can come from the write strobe itself or from a separate latch strobe pin. A busy flag stays high while the conversion runs. When it drops, the finished word is ready on a single serial data pin, and each falling edge of an external serial clock moves it along by one bit.

The analog side is replaced by a fixed-length conversion timer. When the timer expires, the block loads a sample word from a test port. Every strobe pin is asynchronous to the system clock, so each one passes through a two-flop synchroniser, and all edges are detected on the synchronised level. The serial pin is tri-state. It drives only while the part is selected, read is requested and no conversion is running.

Top module: `serial_adc_readout`

## Requirements
- R1: While reset is held and just after it, `status` is 0, `chan_sel` is 0 and `sdo_oe` is 0 when `cs_n` is high.
- R2: When `status` falls, bit 11 of the new result is on `sdo` without any read edge. With `cs_n`=0, `rd_n`=0 and `status`=0, each falling `sclk` edge moves the next lower bit onto `sdo`, ending with bit 0.
- R3: Once bit 0 has been presented, further falling `sclk` edges give `sdo`=0 until the register is reloaded.
- R4: `sdo_oe` is 1 only when `cs_n`=0, `rd_n`=0 and `status`=0. Otherwise `sdo` is high-impedance. This includes the case of `rd_n` low during a conversion.
- R5: A rising edge of `wr_n` with `cs_n`=0 starts a conversion. `status` is then high for exactly CONV_CYCLES clocks, and the word on `sample_in` becomes the result.
- R6: A falling edge of `latch_stb` starts a conversion when `cs_n`=0 and `aden`=1. When `aden`=0 that edge is ignored and `status` stays 0.
- R7: A falling edge of `wr_n` with `cs_n`=0 and `aden`=1 copies `chan_addr` to `chan_sel`. When `aden`=0, `chan_sel` keeps its value.
- R8: With `cs_n`=1, write and strobe edges change neither `status` nor `chan_sel`.
- R9: A start request that arrives while `status` is high is ignored, so the busy period is not stretched.
- R10: A falling edge of `rd_n` with `cs_n`=0 and `status`=0 reloads the last result, so `sdo` returns to bit 11.
- R11: Falling `sclk` edges while `cs_n`=1 do not advance the readout. Reselecting the part continues from the same bit.
- R12: Two's-complement codes come out unaltered, including 0x7FF (positive full scale), 0x800 (negative full scale) and 0xFFF (one code below zero).
- R13: Every pin action takes effect on the third rising clock edge after the pin changes (two synchroniser flops plus the edge detector).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe: the falling edge latches the channel, the rising edge starts a conversion |
| rd_n | input | 1 | Read request, active low |
| aden | input | 1 | Address enable for channel latch and latch strobe |
| latch_stb | input | 1 | Latch strobe: the falling edge starts a conversion |
| sclk | input | 1 | Serial clock: the falling edge advances the readout |
| chan_addr | input | CH_W | Channel address to latch |
| sample_in | input | DATA_W | Test word loaded when a conversion ends |
| status | output | 1 | High while a conversion is running |
| chan_sel | output | CH_W | Latched channel selection |
| sdo | output | 1 | Serial data pin (tri-state) |
| sdo_oe | output | 1 | Drive enable of the serial data pin |

## Verification
The readout is tried with the two full-scale codes, the all-ones code just below zero, and the irregular pattern 0x5A3. The full-scale codes show whether MSB-first order is kept and whether the sign bit survives. The irregular pattern separates a correct bit position from one that is off by a few shifts after a reload or after deselection. Start requests are sent through the write edge, the latch strobe with and without address enable, while deselected, and in the middle of a busy period. Together these show which path started a conversion and whether a conversion was stretched. A behavioural model in the bench tracks the synchroniser delay, so every clock also checks that each action lands on the third edge.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;

  // Positions of the asynchronous control pins in the synchroniser vector.
  localparam int SIG_CS   = 0;
  localparam int SIG_WR   = 1;
  localparam int SIG_RD   = 2;
  localparam int SIG_ADEN = 3;
  localparam int SIG_STB  = 4;
  localparam int SIG_SCK  = 5;
  localparam int NSIG     = 6;

  // Idle level of every pin, so that leaving reset creates no false edge.
  localparam logic [NSIG-1:0] SIG_IDLE = 6'b010111;

  typedef enum logic [1:0] {
    SH_HOLD      = 2'd0,
    SH_LOAD_CONV = 2'd1,
    SH_LOAD_READ = 2'd2,
    SH_SHIFT     = 2'd3
  } sh_op_e;

endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int              W    = 6,
  parameter logic [W-1:0]    IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] level,
  output logic [W-1:0] prev
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= IDLE[i];
        sync_q <= IDLE[i];
        prev_q <= IDLE[i];
      end else begin
        meta_q <= pin[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign level[i] = sync_q;
    assign prev[i]  = prev_q;
  end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = LAST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out
  import adc_serial_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sh_op_e       op,
  input  logic [W-1:0] conv_word,
  output logic         msb
);

  logic [W-1:0] result_q, result_d;
  logic [W-1:0] shreg_q, shreg_d;
  logic         res_en, sh_en;

  always_comb begin
    result_d = result_q;
    shreg_d  = shreg_q;
    res_en   = 1'b0;
    sh_en    = 1'b0;
    unique case (op)
      SH_LOAD_CONV: begin
        result_d = conv_word;
        shreg_d  = conv_word;
        res_en   = 1'b1;
        sh_en    = 1'b1;
      end
      SH_LOAD_READ: begin
        shreg_d = result_q;
        sh_en   = 1'b1;
      end
      SH_SHIFT: begin
        shreg_d = {shreg_q[W-2:0], 1'b0};
        sh_en   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (res_en) begin
      result_q <= result_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else if (sh_en) begin
      shreg_q <= shreg_d;
    end
  end

  assign msb = shreg_q[W-1];

endmodule

// File: rtl/serial_adc_readout.sv
module serial_adc_readout
  import adc_serial_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CH_W        = 3,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              aden,
  input  logic              latch_stb,
  input  logic              sclk,
  input  logic [CH_W-1:0]   chan_addr,
  input  logic [DATA_W-1:0] sample_in,
  output logic              status,
  output logic [CH_W-1:0]   chan_sel,
  output logic              sdo,
  output logic              sdo_oe
);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_core_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  // Pin synchronisation and edge detection.
  logic [NSIG-1:0] pin_raw, sig_lvl, sig_prv;

  assign pin_raw = {sclk, latch_stb, aden, rd_n, wr_n, cs_n};

  adc_sync #(
    .W    (NSIG),
    .IDLE (SIG_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_core_q),
    .pin   (pin_raw),
    .level (sig_lvl),
    .prev  (sig_prv)
  );

  logic unused_prev_bits;
  assign unused_prev_bits = &{1'b0, sig_prv[SIG_CS], sig_prv[SIG_ADEN]};

  logic selected, addr_en, read_lvl;
  logic wr_fall, wr_rise, stb_fall, rd_fall, sck_fall;

  assign selected = !sig_lvl[SIG_CS];
  assign addr_en  = sig_lvl[SIG_ADEN];
  assign read_lvl = !sig_lvl[SIG_RD];
  assign wr_fall  = sig_prv[SIG_WR]  && !sig_lvl[SIG_WR];
  assign wr_rise  = !sig_prv[SIG_WR] && sig_lvl[SIG_WR];
  assign stb_fall = sig_prv[SIG_STB] && !sig_lvl[SIG_STB];
  assign rd_fall  = sig_prv[SIG_RD]  && !sig_lvl[SIG_RD];
  assign sck_fall = sig_prv[SIG_SCK] && !sig_lvl[SIG_SCK];

  // Conversion timer.
  logic conv_start, conv_busy, conv_done;

  assign conv_start = selected && (wr_rise || (stb_fall && addr_en));

  adc_conv_timer #(
    .CYCLES (CONV_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_core_q),
    .start (conv_start),
    .busy  (conv_busy),
    .done  (conv_done)
  );

  // Channel latch.
  logic [CH_W-1:0] chan_q, chan_d;
  logic            chan_en;

  always_comb begin
    chan_en = selected && addr_en && wr_fall;
    chan_d  = chan_addr;
  end

  always_ff @(posedge clk or negedge rst_core_q) begin
    if (!rst_core_q) begin
      chan_q <= '0;
    end else if (chan_en) begin
      chan_q <= chan_d;
    end
  end

  // Readout control; end of conversion takes priority over a read edge.
  sh_op_e sh_op;
  logic   port_open;
  logic   sh_msb;

  assign port_open = selected && read_lvl && !conv_busy;

  always_comb begin
    sh_op = SH_HOLD;
    if (conv_done) begin
      sh_op = SH_LOAD_CONV;
    end else if (selected && rd_fall) begin
      sh_op = SH_LOAD_READ;
    end else if (port_open && sck_fall) begin
      sh_op = SH_SHIFT;
    end
  end

  adc_shift_out #(
    .W (DATA_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_core_q),
    .op        (sh_op),
    .conv_word (sample_in),
    .msb       (sh_msb)
  );

  assign status   = conv_busy;
  assign chan_sel = chan_q;
  assign sdo_oe   = port_open;
  assign sdo      = port_open ? sh_msb : 1'bz;

endmodule

// File: rtl/adc_serial_checker.sv
module adc_serial_checker #(
  parameter int CONV_CYCLES = 40
) (
  input logic clk,
  input logic rst_n,
  input logic status,
  input logic sdo_oe,
  input logic sh_msb,
  input logic sample_msb,
  input logic cs_idle
);

  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
    end else if (status) begin
      run_q <= run_q + 1;
    end else begin
      run_q <= 0;
    end
  end

  assert_oe_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !status);

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |-> (run_q == CONV_CYCLES));

  assert_msb_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |-> (sh_msb == $past(sample_msb)));

  assert_deselect_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_idle && !status) |=> !status);

endmodule

bind serial_adc_readout adc_serial_checker #(
  .CONV_CYCLES (CONV_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .status     (status),
  .sdo_oe     (sdo_oe),
  .sh_msb     (sh_msb),
  .sample_msb (sample_in[DATA_W-1]),
  .cs_idle    (sig_lvl[adc_serial_pkg::SIG_CS])
);

// File: tb/sim_serial_adc_readout.sv
module sim_serial_adc_readout;

  localparam int N = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, aden = 1'b0;
  logic        latch_stb = 1'b1, sclk = 1'b0;
  logic [2:0]  chan_addr = '0;
  logic [11:0] sample_in = '0;
  logic        status, sdo, sdo_oe;
  logic [2:0]  chan_sel;

  int  checks = 0;
  int  errors = 0;
  bit  cmp_en = 1'b0;
  bit  finished = 1'b0;
  int  run_len = 0;
  int  last_run = 0;

  always #5 clk = ~clk;

  serial_adc_readout #(.DATA_W(12), .CH_W(3), .CONV_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .aden(aden), .latch_stb(latch_stb), .sclk(sclk), .chan_addr(chan_addr),
    .sample_in(sample_in), .status(status), .chan_sel(chan_sel),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: pins reach the logic two clocks late, edges a clock after that.
  bit [5:0]   m_s1, m_s2, m_p;
  bit         m_busy;
  int         m_cnt, m_idx;
  logic [11:0] m_res, m_word;
  logic [2:0] m_chan;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 6'b010111; m_s2 = 6'b010111; m_p = 6'b010111;
      m_busy = 0; m_cnt = 0; m_idx = 0;
      m_res = '0; m_word = '0; m_chan = '0;
    end else begin
      bit sel, busy_old, done;
      sel = !m_s2[0];
      busy_old = m_busy;
      done = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0; m_res = sample_in; m_word = sample_in; m_idx = 0; done = 1;
        end else m_cnt--;
      end else if (sel && ((!m_p[1] && m_s2[1]) || (m_p[4] && !m_s2[4] && m_s2[3]))) begin
        m_busy = 1; m_cnt = N - 1;
      end
      if (sel && m_s2[3] && m_p[1] && !m_s2[1]) m_chan = chan_addr;
      if (!done) begin
        if (sel && m_p[2] && !m_s2[2]) begin
          m_word = m_res; m_idx = 0;
        end else if (sel && !m_s2[2] && !busy_old && m_p[5] && !m_s2[5]) begin
          m_idx++;
        end
      end
      m_p = m_s2; m_s2 = m_s1;
      m_s1 = {sclk, latch_stb, aden, rd_n, wr_n, cs_n};
    end
  end

  // Per-clock comparison (R13 timing), plus busy-run measurement.
  always @(negedge clk) begin
    if (status) run_len++;
    else if (run_len > 0) begin last_run = run_len; run_len = 0; end
    if (cmp_en) begin
      bit e_oe, e_sdo;
      e_oe  = !m_s2[0] && !m_s2[2] && !m_busy;
      e_sdo = (m_idx < 12) ? m_word[11 - m_idx] : 1'b0;
      chk(status === m_busy, "R13 status", int'(status), int'(m_busy));
      chk(chan_sel === m_chan, "R13 chan_sel", int'(chan_sel), int'(m_chan));
      chk(sdo_oe === e_oe, "R13 sdo_oe", int'(sdo_oe), int'(e_oe));
      if (e_oe) chk(sdo === e_sdo, "R13 sdo", int'(sdo), int'(e_sdo));
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pulse();
    wr_n = 1'b0; wait_n(5);
    wr_n = 1'b1; wait_n(5);
  endtask

  task automatic sck_pulse();
    sclk = 1'b1; wait_n(4);
    sclk = 1'b0; wait_n(4);
  endtask

  task automatic read_word(input logic [11:0] w, input string tag);
    rd_n = 1'b0; wait_n(5);
    chk(sdo_oe === 1'b1, {tag, " oe"}, int'(sdo_oe), 1);
    chk(sdo === w[11], {tag, " bit11"}, int'(sdo), int'(w[11]));
    for (int i = 10; i >= 0; i--) begin
      sck_pulse();
      chk(sdo === w[i], {tag, " bit"}, int'(sdo), int'(w[i]));
    end
    for (int k = 0; k < 2; k++) begin
      sck_pulse();
      chk(sdo === 1'b0, "R3 zero fill", int'(sdo), 0);
    end
    rd_n = 1'b1; wait_n(5);
  endtask

  initial begin
    wait_n(3);
    chk(status === 1'b0, "R1 status in reset", int'(status), 0);
    chk(chan_sel === 3'd0, "R1 chan in reset", int'(chan_sel), 0);
    chk(sdo_oe === 1'b0, "R1 oe in reset", int'(sdo_oe), 0);
    rst_n = 1'b1;
    wait_n(6);
    chk(status === 1'b0, "R1 status after reset", int'(status), 0);
    cmp_en = 1'b1;

    // R5 / R7 / R12: write-started conversion, positive full scale.
    aden = 1'b1; cs_n = 1'b0; chan_addr = 3'd5; sample_in = 12'h7FF;
    wr_pulse();
    chk(status === 1'b1, "R5 busy", int'(status), 1);
    wait_n(N);
    chk(last_run == N, "R5 busy length", last_run, N);
    chk(chan_sel === 3'd5, "R7 channel latched", int'(chan_sel), 5);
    read_word(12'h7FF, "R12 R2 0x7FF");
    chk(sdo_oe === 1'b0, "R4 rd high", int'(sdo_oe), 0);

    // R4 / R2: read held low across a conversion, MSB appears at status fall.
    rd_n = 1'b0; sample_in = 12'h800;
    wr_pulse();
    chk(sdo_oe === 1'b0, "R4 oe off while busy", int'(sdo_oe), 0);
    wait_n(N);
    chk(sdo_oe === 1'b1, "R4 oe after done", int'(sdo_oe), 1);
    chk(sdo === 1'b1, "R2 msb at status fall", int'(sdo), 1);
    rd_n = 1'b1; wait_n(5);
    read_word(12'h800, "R12 R2 0x800");

    // R7: channel ignored with aden low; write still starts.
    aden = 1'b0; chan_addr = 3'd3;
    wr_pulse();
    chk(chan_sel === 3'd5, "R7 aden low keeps channel", int'(chan_sel), 5);
    wait_n(N);

    // R6: latch strobe ignored with aden low, honoured with aden high.
    latch_stb = 1'b0; wait_n(6);
    chk(status === 1'b0, "R6 strobe ignored", int'(status), 0);
    latch_stb = 1'b1; wait_n(5);
    aden = 1'b1; chan_addr = 3'd5;
    latch_stb = 1'b0; wait_n(4);
    chk(status === 1'b1, "R6 strobe start", int'(status), 1);
    latch_stb = 1'b1;
    wait_n(N + 2);

    // R9: second start mid-conversion ignored.
    sample_in = 12'hFFF;
    wr_pulse();
    wait_n(8);
    wr_pulse();
    wait_n(N);
    chk(last_run == N, "R9 busy not stretched", last_run, N);
    read_word(12'hFFF, "R12 R2 0xFFF");

    // R10: reload on read edge.
    sample_in = 12'h5A3;
    wr_pulse(); wait_n(N);
    rd_n = 1'b0; wait_n(5);
    for (int k = 0; k < 3; k++) sck_pulse();
    chk(sdo === 1'b1, "R10 bit8 before reload", int'(sdo), 1);
    rd_n = 1'b1; wait_n(5);
    rd_n = 1'b0; wait_n(5);
    chk(sdo === 1'b0, "R10 bit11 after reload", int'(sdo), 0);

    // R11 / R8: deselected serial clocks and writes do nothing.
    sck_pulse(); sck_pulse();
    cs_n = 1'b1; wait_n(5);
    chk(sdo_oe === 1'b0, "R4 oe off deselected", int'(sdo_oe), 0);
    sck_pulse(); sck_pulse();
    chan_addr = 3'd6;
    wr_pulse();
    chk(status === 1'b0, "R8 no start deselected", int'(status), 0);
    chk(chan_sel === 3'd5, "R8 channel kept", int'(chan_sel), 5);
    cs_n = 1'b0; wait_n(5);
    chk(sdo === 1'b0, "R11 bit9 kept", int'(sdo), 0);
    sck_pulse();
    chk(sdo === 1'b1, "R11 bit8 next", int'(sdo), 1);
    rd_n = 1'b1; wait_n(5);

    cmp_en = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule